// File: doc/BRIEF.md
# Video Pixel Byte Packer

This block turns a stream of processed pixels into bytes on an 8-bit video output bus, at most one byte per clock. Each pixel arrives as a 24-bit word with a valid strobe. A two-bit format selector chooses YCbCr 4:2:2, RGB565 or 10-bit raw sensor samples. A two-bit order selector picks the byte arrangement within that format. The output is a byte bus with a byte-valid flag that is only ever raised inside the active line window.

Format and order are read from the configuration pins only on a frame-start pulse, so a frame is never packed in two ways. A pixel parity counter sets whether a YCbCr pixel carries Cb (even) or Cr (odd). It restarts at zero on every line, so each line opens with the first pixel of a chroma pair. In modes that give two bytes per pixel, upstream spaces its pixels two cycles apart. In one-byte modes pixels may arrive every cycle.

Top module: `vid_byte_packer`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0 and `out_data` is 0. Whenever `out_valid` is 0, `out_data` is 0.
- R2: Format 0 with order 0 (chroma first): each pixel emits its chroma byte, then its luma byte. Luma is `pix_data[23:16]`. Chroma is Cb `pix_data[15:8]` on even pixels of a line and Cr `pix_data[7:0]` on odd ones.
- R3: Format 0 with order 1 (luma first): each pixel emits luma, then the parity-selected chroma byte.
- R4: Format 0 with order 2 emits only the luma byte of each pixel. Format 0 with order 3 emits only the parity-selected chroma byte.
- R5: Format 1 with order bit 0 clear (R=`pix_data[15:11]`, G=`[10:5]`, B=`[4:0]`) emits {R, G[5:3]} and then {G[2:0], B}.
- R6: Format 1 with order bit 0 set emits {B, G[5:3]} and then {G[2:0], R}.
- R7: Formats 2 and 3 (raw) emit {6'b0, D[9:8]} and then D[7:0], with D=`pix_data[9:0]`, whatever the order setting.
- R8: The first byte of a pixel accepted at one clock edge is valid after the next edge. A second byte follows one cycle later. A new pixel that arrives while a second byte is pending takes precedence, and the pending byte is dropped.
- R9: The pixel parity is reset to even whenever `line_active` is low, so the first pixel of every line is even.
- R10: Format and order change only on the clock edge that samples `frame_start` high. Pin changes at any other time have no effect on the bytes.
- R11: While `line_active` is low, `pix_valid` is ignored and any pending second byte is discarded. `out_valid` is 0 in the cycle after any cycle with `line_active` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel/byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse that loads the format and order selectors |
| cfg_fmt | input | 2 | Format: 0 YCbCr, 1 RGB565, 2/3 raw |
| cfg_ord | input | 2 | Byte order within the format |
| line_active | input | 1 | High during the active part of a line |
| pix_valid | input | 1 | Pixel strobe |
| pix_data | input | 24 | Pixel word (layout per format, see requirements) |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |

## Verification
Two corner cases are hard to reach from the ports: a pending second byte lost because the line window closes, and one overtaken by a pixel that arrives too early. The bench drives both deliberately at the cycle where the first byte appears. It also opens a new line after an odd pixel count in chroma-only mode, so that a parity counter that failed to restart would show up as Cr in place of Cb. Random frames then mix all formats, orders and line lengths, and a bench model tracks the parity on its own.

// File: rtl/vbp_pkg.sv
package vbp_pkg;
  localparam int BYTE_W = 8;
  localparam int PIX_W  = 24;
  localparam int RAW_W  = 10;

  typedef enum logic [1:0] {
    FMT_YC  = 2'd0,
    FMT_RGB = 2'd1,
    FMT_RAW = 2'd2,
    FMT_RAW2 = 2'd3
  } fmt_e;

  localparam logic [1:0] ORD_C_FIRST = 2'd0;
  localparam logic [1:0] ORD_Y_FIRST = 2'd1;
  localparam logic [1:0] ORD_Y_ONLY  = 2'd2;
  localparam logic [1:0] ORD_C_ONLY  = 2'd3;

  typedef struct packed {
    logic [BYTE_W-1:0] first;
    logic [BYTE_W-1:0] second;
    logic              two;
  } byte_pair_t;
endpackage

// File: rtl/vbp_cfg_hold.sv
module vbp_cfg_hold
  import vbp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic [1:0] cfg_fmt_i,
  input  logic [1:0] cfg_ord_i,
  output fmt_e       fmt_o,
  output logic [1:0] ord_o
);
  fmt_e       fmt_q, fmt_d;
  logic [1:0] ord_q, ord_d;
  logic       load_en;

  always_comb begin
    load_en = frame_start;
    fmt_d   = fmt_e'(cfg_fmt_i);
    ord_d   = cfg_ord_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q <= FMT_YC;
      ord_q <= ORD_C_FIRST;
    end else if (load_en) begin
      fmt_q <= fmt_d;
      ord_q <= ord_d;
    end
  end

  assign fmt_o = fmt_q;
  assign ord_o = ord_q;

  // R10
  cfg_fmt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(fmt_q));
  // R10
  cfg_ord_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(ord_q));
endmodule

// File: rtl/vbp_byte_build.sv
module vbp_byte_build
  import vbp_pkg::*;
(
  input  fmt_e             fmt_i,
  input  logic [1:0]       ord_i,
  input  logic             odd_i,
  input  logic [PIX_W-1:0] pix_i,
  output byte_pair_t       pair_o
);
  logic [BYTE_W-1:0] luma, chroma;
  logic [4:0]        red, blue;
  logic [5:0]        green;
  logic [RAW_W-1:0]  raw;

  always_comb begin
    luma   = pix_i[23:16];
    chroma = odd_i ? pix_i[7:0] : pix_i[15:8];
    red    = pix_i[15:11];
    green  = pix_i[10:5];
    blue   = pix_i[4:0];
    raw    = pix_i[RAW_W-1:0];
    pair_o = '0;
    unique case (fmt_i)
      FMT_YC: begin
        unique case (ord_i)
          ORD_C_FIRST: pair_o = '{first: chroma, second: luma, two: 1'b1};
          ORD_Y_FIRST: pair_o = '{first: luma, second: chroma, two: 1'b1};
          ORD_Y_ONLY:  pair_o = '{first: luma, second: '0, two: 1'b0};
          default:     pair_o = '{first: chroma, second: '0, two: 1'b0};
        endcase
      end
      FMT_RGB: begin
        if (ord_i[0])
          pair_o = '{first: {blue, green[5:3]}, second: {green[2:0], red}, two: 1'b1};
        else
          pair_o = '{first: {red, green[5:3]}, second: {green[2:0], blue}, two: 1'b1};
      end
      default: begin
        pair_o = '{first: {{(BYTE_W-(RAW_W-BYTE_W)){1'b0}}, raw[RAW_W-1:BYTE_W]},
                   second: raw[BYTE_W-1:0], two: 1'b1};
      end
    endcase
  end
endmodule

// File: rtl/vbp_byte_seq.sv
module vbp_byte_seq
  import vbp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_active,
  input  logic              pix_valid,
  input  byte_pair_t        pair_i,
  output logic              odd_o,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data
);
  logic              valid_q, valid_d;
  logic [BYTE_W-1:0] data_q, data_d;
  logic [BYTE_W-1:0] hold_q;
  logic              pend_q, pend_d;
  logic              odd_q, odd_d;
  logic              hold_en;
  logic              take;

  always_comb begin
    take    = line_active && pix_valid;
    hold_en = take && pair_i.two;
    valid_d = 1'b0;
    data_d  = '0;
    pend_d  = 1'b0;
    odd_d   = odd_q;
    if (!line_active) begin
      odd_d = 1'b0;
    end else if (take) begin
      valid_d = 1'b1;
      data_d  = pair_i.first;
      pend_d  = pair_i.two;
      odd_d   = ~odd_q;
    end else if (pend_q) begin
      valid_d = 1'b1;
      data_d  = hold_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      pend_q  <= 1'b0;
      odd_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
      pend_q  <= pend_d;
      odd_q   <= odd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= pair_i.second;
  end

  assign odd_o     = odd_q;
  assign out_valid = valid_q;
  assign out_data  = data_q;

  // R11
  window_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_active |=> !out_valid);
  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_data == '0));
  // R9
  parity_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_active |=> !odd_q);
  // R8
  second_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_active && pix_valid && pair_i.two) ##1 (line_active && !pix_valid)
      |=> (out_valid && out_data == $past(pair_i.second, 2)));
  // R8
  first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_active && pix_valid) |=> (out_valid && out_data == $past(pair_i.first)));
endmodule

// File: rtl/vid_byte_packer.sv
module vid_byte_packer
  import vbp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [1:0]        cfg_fmt,
  input  logic [1:0]        cfg_ord,
  input  logic              line_active,
  input  logic              pix_valid,
  input  logic [PIX_W-1:0]  pix_data,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data
);
  fmt_e       act_fmt;
  logic [1:0] act_ord;
  logic       odd;
  byte_pair_t pair;

  vbp_cfg_hold u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .cfg_fmt_i  (cfg_fmt),
    .cfg_ord_i  (cfg_ord),
    .fmt_o      (act_fmt),
    .ord_o      (act_ord)
  );

  vbp_byte_build u_build (
    .fmt_i (act_fmt),
    .ord_i (act_ord),
    .odd_i (odd),
    .pix_i (pix_data),
    .pair_o(pair)
  );

  vbp_byte_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_active(line_active),
    .pix_valid  (pix_valid),
    .pair_i     (pair),
    .odd_o      (odd),
    .out_valid  (out_valid),
    .out_data   (out_data)
  );
endmodule

// File: tb/vid_byte_packer_bench.sv
`timescale 1ns/1ps
module vid_byte_packer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_start;
  logic [1:0]  cfg_fmt, cfg_ord;
  logic        line_active;
  logic        pix_valid;
  logic [23:0] pix_data;
  logic        out_valid;
  logic [7:0]  out_data;

  int  errs = 0;
  int  checks = 0;
  bit  done = 0;
  bit  par;
  logic [1:0] m_fmt, m_ord;

  always #2.5 clk = ~clk;

  vid_byte_packer u_vid_byte_packer (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .cfg_fmt(cfg_fmt), .cfg_ord(cfg_ord), .line_active(line_active),
    .pix_valid(pix_valid), .pix_data(pix_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [1:0] f, input logic [1:0] o, input bit odd,
                                input logic [23:0] d, output logic [7:0] e0,
                                output logic [7:0] e1, output bit two);
    logic [7:0] y, c;
    y = d[23:16];
    c = odd ? d[7:0] : d[15:8];
    e1 = 8'h00;
    two = 1;
    if (f == 2'd0) begin
      case (o)
        2'd0: begin e0 = c; e1 = y; end
        2'd1: begin e0 = y; e1 = c; end
        2'd2: begin e0 = y; two = 0; end
        default: begin e0 = c; two = 0; end
      endcase
    end else if (f == 2'd1) begin
      if (o[0]) begin e0 = {d[4:0], d[10:8]}; e1 = {d[7:5], d[15:11]}; end
      else      begin e0 = {d[15:8]};         e1 = {d[7:0]}; end
    end else begin
      e0 = {6'b0, d[9:8]};
      e1 = d[7:0];
    end
  endfunction

  function automatic string tag(input logic [1:0] f, input logic [1:0] o);
    if (f == 2'd0) return (o == 2'd0) ? "R2" : (o == 2'd1) ? "R3" : "R4";
    if (f == 2'd1) return o[0] ? "R6" : "R5";
    return "R7";
  endfunction

  // entered and left at a falling edge
  task automatic send_px(input logic [23:0] d, input string req);
    logic [7:0] e0, e1;
    bit two;
    model(m_fmt, m_ord, par, d, e0, e1, two);
    pix_valid = 1; pix_data = d;
    @(negedge clk);
    pix_valid = 0;
    chk({req, " valid b0"}, {7'b0, out_valid}, 8'h01);
    chk({req, " byte0"}, out_data, e0);
    par = ~par;
    if (two) begin
      @(negedge clk);
      chk({req, " valid b1"}, {7'b0, out_valid}, 8'h01);
      chk({req, " byte1"}, out_data, e1);
    end
  endtask

  task automatic new_frame(input logic [1:0] f, input logic [1:0] o);
    line_active = 0;
    cfg_fmt = f; cfg_ord = o; frame_start = 1;
    @(negedge clk);
    frame_start = 0;
    m_fmt = f; m_ord = o;
    @(negedge clk);
  endtask

  task automatic open_line();
    line_active = 1; par = 0;
  endtask

  task automatic close_line();
    line_active = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R11 idle after line", {7'b0, out_valid}, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL R8 watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; frame_start = 0; cfg_fmt = 0; cfg_ord = 0;
    line_active = 0; pix_valid = 0; pix_data = '0; par = 0;
    m_fmt = 0; m_ord = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {7'b0, out_valid}, 8'h00);
    chk("R1 reset data", out_data, 8'h00);
    rst_n = 1;
    @(negedge clk);
    chk("R1 post-reset valid", {7'b0, out_valid}, 8'h00);
    chk("R1 post-reset data", out_data, 8'h00);

    // R2 chroma first: Cb of pixel 0, Cr of pixel 1
    new_frame(2'd0, 2'd0);
    open_line();
    send_px(24'h11_22_33, "R2");
    send_px(24'h44_55_66, "R2");
    close_line();
    // R3 luma first
    new_frame(2'd0, 2'd1);
    open_line();
    send_px(24'hA0_B0_C0, "R3");
    send_px(24'hA1_B1_C1, "R3");
    close_line();
    // R4 luma only, back to back
    new_frame(2'd0, 2'd2);
    open_line();
    send_px(24'h10_20_30, "R4");
    send_px(24'h40_50_60, "R4");
    close_line();
    // R4 chroma only, and R9 restart after odd count
    new_frame(2'd0, 2'd3);
    open_line();
    send_px(24'h01_02_03, "R4");
    send_px(24'h04_05_06, "R4");
    send_px(24'h07_08_09, "R4");
    close_line();
    open_line();
    send_px(24'h0A_0B_0C, "R9 first pixel even");
    close_line();

    // R5 RGB normal corners
    new_frame(2'd1, 2'd0);
    open_line();
    send_px({8'h00, 5'h1F, 6'h00, 5'h00}, "R5");
    send_px({8'h00, 5'h00, 6'h3F, 5'h00}, "R5");
    send_px({8'h00, 5'h00, 6'h00, 5'h1F}, "R5");
    close_line();
    // R6 RGB swapped
    new_frame(2'd1, 2'd1);
    open_line();
    send_px({8'h00, 5'h1F, 6'h00, 5'h00}, "R6");
    send_px({8'h00, 5'h00, 6'h2A, 5'h15}, "R6");
    close_line();
    // R7 raw, order ignored
    new_frame(2'd2, 2'd3);
    open_line();
    send_px(24'h0003FF, "R7");
    send_px(24'hFFF200, "R7");
    close_line();
    new_frame(2'd3, 2'd1);
    open_line();
    send_px(24'h000155, "R7");
    close_line();

    // R10: pin change without frame_start has no effect
    new_frame(2'd1, 2'd0);
    cfg_fmt = 2'd2; cfg_ord = 2'd1;
    @(negedge clk);
    open_line();
    send_px({8'h00, 5'h12, 6'h2D, 5'h09}, "R10 old format kept");
    close_line();
    new_frame(2'd2, 2'd1);
    open_line();
    send_px(24'h000321, "R10 new format after frame start");
    close_line();

    // R11: pix_valid ignored outside window
    line_active = 0; pix_valid = 1; pix_data = 24'h123456;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R11 ignored pixel", {7'b0, out_valid}, 8'h00);
    end
    pix_valid = 0;
    // R11: pending second byte dropped when the window closes
    open_line();
    pix_valid = 1; pix_data = 24'h0002AB;
    @(negedge clk);
    pix_valid = 0; line_active = 0;
    chk("R11 first byte before drop", out_data, 8'h02);
    @(negedge clk);
    chk("R11 pending dropped", {7'b0, out_valid}, 8'h00);

    // R8: early pixel overtakes pending second byte
    new_frame(2'd0, 2'd0);
    open_line();
    pix_valid = 1; pix_data = 24'hAA_BB_CC;
    @(negedge clk);
    pix_data = 24'hDD_EE_FF;
    chk("R8 first pixel byte0", out_data, 8'hBB);
    @(negedge clk);
    pix_valid = 0;
    chk("R8 overtaking pixel byte0 (Cr)", out_data, 8'hFF);
    @(negedge clk);
    chk("R8 overtaking pixel byte1", out_data, 8'hDD);
    @(negedge clk);
    chk("R8 nothing after pair", {7'b0, out_valid}, 8'h00);
    close_line();

    // random frames
    for (int fr = 0; fr < 40; fr++) begin
      logic [1:0] f, o;
      f = 2'($urandom_range(0, 3));
      o = 2'($urandom_range(0, 3));
      new_frame(f, o);
      for (int ln = 0; ln < 3; ln++) begin
        int n;
        n = $urandom_range(1, 8);
        open_line();
        for (int p = 0; p < n; p++) send_px(24'($urandom), tag(f, o));
        close_line();
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule